// File: doc/BRIEF.md
# Viterbi Add-Compare-Select Stage

This block advances the path metrics of a Viterbi decoder by one trellis stage. A stage is launched by pulsing `start_i` while the block is idle, with the incremental branch metrics of every transition in the stage presented at the same time. The block then does three things for each next state. It forms the two candidate metrics from its two predecessor states. It keeps the smaller of the two in a bank of 24-bit registers. It records which predecessor survived as a single decision bit.

Path metrics are never renormalized. They saturate at the top of their range, and a one-cycle warning tells the controlling logic that a metric is getting close to the ceiling. At the end of each stage the index of the cheapest state is held on `min_idx_o`, which a traceback engine uses as its starting point. The decision bits are packed 16 to a word and written out over consecutive cycles into a traceback bank, at addresses that run on from stage to stage and wrap at the end of the bank.

Top module: `vit_acs_update`

## Requirements
- R1: After reset all path metrics are zero, and `busy_o`, `dec_we_o`, `near_ovf_o` and `min_idx_o` are all zero.
- R2: On an accepted stage, next state s has first predecessor p0 = (2s) mod S and second predecessor p0+1, where S = 2^(C-1). The first candidate uses the branch metric in `bm_i` slot 2s and the second uses slot 2s+1, where slot k occupies bits [16k+15:16k]. The new metric of s is the smaller candidate.
- R3: The decision bit of state s is 1 only when the second candidate is strictly smaller than the first. On a tie it is 0.
- R4: A candidate sum of 2^24 or more is replaced by 2^24-1 before the comparison.
- R5: `near_ovf_o` is high for exactly the one cycle after an accepted stage, and only when at least one updated metric has bits 23 and 22 both set.
- R6: `min_idx_o` updates when a stage is accepted, to the index of the smallest updated metric. On a tie the lowest index wins.
- R7: In the cycles after an accepted stage, `dec_we_o` and `busy_o` are high for ceil(S/16) cycles. In cycle w of these, `dec_data_o` bit b carries the decision of state 16w+b.
- R8: `dec_addr_o` starts at 0 after reset and advances by one for every word written. It wraps from BANK_DEPTH-1 to 0.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the metrics nor the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one trellis stage (accepted only when idle) |
| bm_i | input | 16·2^C | Branch metrics, slot k at bits [16k+15:16k] |
| busy_o | output | 1 | Decision words are being written |
| dec_we_o | output | 1 | Traceback bank write strobe |
| dec_addr_o | output | log2(BANK_DEPTH) | Traceback bank word address |
| dec_data_o | output | 16 | Packed survivor decisions |
| near_ovf_o | output | 1 | One-cycle near-overflow warning |
| min_idx_o | output | C-1 | Index of the minimum-metric state |

## Verification
The bench first drives all-equal branch metrics. A design that broke ties toward the second predecessor, or toward the highest index, would then produce all-ones decisions or a nonzero `min_idx_o`. It next drives maximum metrics for several hundred stages, so the metrics cross the warning threshold and then reach the ceiling. A wrapping adder would suddenly make some states look cheap, and a wrong threshold would move the warning stage. The bench also lets the address counter wrap several times, and it fires a stray start in the middle of a write burst. A design that accepted that start would shift the addresses and leave the metrics different from those of the bench's own model.

// File: rtl/vacs_pkg.sv
package vacs_pkg;
  localparam int unsigned DEC_WORD_W = 16;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/vacs_pe.sv
module vacs_pe #(
  parameter int unsigned PM_W = 24,
  parameter int unsigned BM_W = 16
) (
  input  logic [PM_W-1:0] pm0_i,
  input  logic [PM_W-1:0] pm1_i,
  input  logic [BM_W-1:0] bm0_i,
  input  logic [BM_W-1:0] bm1_i,
  output logic [PM_W-1:0] pm_o,
  output logic            dec_o,
  output logic            near_o
);
  localparam logic [PM_W-1:0] PM_MAX = {PM_W{1'b1}};

  logic [PM_W:0]   sum0, sum1;
  logic [PM_W-1:0] cand0, cand1;

  assign sum0  = {1'b0, pm0_i} + {{(PM_W+1-BM_W){1'b0}}, bm0_i};
  assign sum1  = {1'b0, pm1_i} + {{(PM_W+1-BM_W){1'b0}}, bm1_i};
  // saturate instead of wrapping
  assign cand0 = sum0[PM_W] ? PM_MAX : sum0[PM_W-1:0];
  assign cand1 = sum1[PM_W] ? PM_MAX : sum1[PM_W-1:0];

  // strict compare: tie keeps first predecessor
  assign dec_o  = cand1 < cand0;
  assign pm_o   = dec_o ? cand1 : cand0;
  assign near_o = &pm_o[PM_W-1 -: 2];
endmodule

// File: rtl/vacs_min_tree.sv
module vacs_min_tree #(
  parameter int unsigned N    = 64,
  parameter int unsigned PM_W = 24,
  localparam int unsigned LVLS  = $clog2(N),
  localparam int unsigned IDX_W = (LVLS < 1) ? 1 : LVLS
) (
  input  logic [N*PM_W-1:0] val_i,
  output logic [IDX_W-1:0]  idx_o
);
  genvar l, i;
  generate
    for (l = 1; l <= LVLS; l++) begin : g_lvl
      localparam int unsigned W = N >> l;
      logic [PM_W-1:0]  v  [W];
      logic [IDX_W-1:0] ix [W];
      for (i = 0; i < W; i++) begin : g_node
        if (l == 1) begin : g_leaf
          logic [PM_W-1:0] a, b;
          assign a = val_i[(2*i)*PM_W +: PM_W];
          assign b = val_i[(2*i+1)*PM_W +: PM_W];
          // lower index wins on equal values
          assign v[i]  = (b < a) ? b : a;
          assign ix[i] = (b < a) ? IDX_W'(2*i+1) : IDX_W'(2*i);
        end else begin : g_inner
          logic take_b;
          assign take_b = g_lvl[l-1].v[2*i+1] < g_lvl[l-1].v[2*i];
          assign v[i]  = take_b ? g_lvl[l-1].v[2*i+1]  : g_lvl[l-1].v[2*i];
          assign ix[i] = take_b ? g_lvl[l-1].ix[2*i+1] : g_lvl[l-1].ix[2*i];
        end
      end
    end
    if (LVLS == 0) begin : g_single
      assign idx_o = '0;
    end else begin : g_root
      assign idx_o = g_lvl[LVLS].ix[0];
    end
  endgenerate
endmodule

// File: rtl/vacs_dec_writer.sv
module vacs_dec_writer #(
  parameter int unsigned N          = 64,
  parameter int unsigned BANK_DEPTH = 1024,
  localparam int unsigned WORD_W = vacs_pkg::DEC_WORD_W,
  localparam int unsigned WORDS  = vacs_pkg::ceil_div(N, WORD_W),
  localparam int unsigned CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned ADDR_W = $clog2(BANK_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N-1:0]      dec_i,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o
);
  logic [WORDS*WORD_W-1:0] dec_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [ADDR_W-1:0]       addr_q;
  logic                    busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      addr_q <= addr_q + 1'b1;  // power-of-two bank: natural wrap
      if (cnt_q == CNT_W'(WORDS-1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (load_i) begin
      dec_q  <= {{(WORDS*WORD_W-N){1'b0}}, dec_i};
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign addr_o = addr_q;
  assign data_o = dec_q[cnt_q*WORD_W +: WORD_W];

  p_addr_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (addr_q == $past(addr_q) + 1'b1));
  p_first_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q == '0));
  p_burst_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == CNT_W'(WORDS-1)) |=> !busy_q);
endmodule

// File: rtl/vit_acs_update.sv
module vit_acs_update #(
  parameter int unsigned C          = 7,
  parameter int unsigned PM_W       = 24,
  parameter int unsigned BM_W       = 16,
  parameter int unsigned BANK_DEPTH = 1024,
  localparam int unsigned N      = 1 << (C-1),
  localparam int unsigned T      = 1 << C,
  localparam int unsigned IDX_W  = C-1,
  localparam int unsigned ADDR_W = $clog2(BANK_DEPTH),
  localparam int unsigned WORD_W = vacs_pkg::DEC_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [T*BM_W-1:0] bm_i,
  output logic              busy_o,
  output logic              dec_we_o,
  output logic [ADDR_W-1:0] dec_addr_o,
  output logic [WORD_W-1:0] dec_data_o,
  output logic              near_ovf_o,
  output logic [IDX_W-1:0]  min_idx_o
);
  logic [PM_W-1:0]   pm_q   [N];
  logic [PM_W-1:0]   pm_nxt [N];
  logic [N-1:0]      dec, near;
  logic [N*PM_W-1:0] nxt_flat, cur_flat;
  logic [IDX_W-1:0]  min_idx_d, min_idx_q;
  logic              near_q, accept;

  assign accept = start_i && !busy_o;

  genvar s;
  generate
    for (s = 0; s < N; s++) begin : g_state
      localparam int unsigned P0 = (2*s) % N;
      vacs_pe #(.PM_W(PM_W), .BM_W(BM_W)) u_pe (
        .pm0_i (pm_q[P0]),
        .pm1_i (pm_q[P0+1]),
        .bm0_i (bm_i[(2*s)*BM_W +: BM_W]),
        .bm1_i (bm_i[(2*s+1)*BM_W +: BM_W]),
        .pm_o  (pm_nxt[s]),
        .dec_o (dec[s]),
        .near_o(near[s])
      );
      assign nxt_flat[s*PM_W +: PM_W] = pm_nxt[s];
      assign cur_flat[s*PM_W +: PM_W] = pm_q[s];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pm_q[s] <= '0;
        else if (accept) pm_q[s] <= pm_nxt[s];
      end

      p_min_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pm_q[min_idx_q] <= pm_q[s]);
    end
  endgenerate

  vacs_min_tree #(.N(N), .PM_W(PM_W)) u_min (
    .val_i(nxt_flat),
    .idx_o(min_idx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_idx_q <= '0;
      near_q    <= 1'b0;
    end else begin
      near_q <= accept && (|near);
      if (accept) min_idx_q <= min_idx_d;
    end
  end

  vacs_dec_writer #(.N(N), .BANK_DEPTH(BANK_DEPTH)) u_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .dec_i (dec),
    .busy_o(busy_o),
    .we_o  (dec_we_o),
    .addr_o(dec_addr_o),
    .data_o(dec_data_o)
  );

  assign near_ovf_o = near_q;
  assign min_idx_o  = min_idx_q;

  p_near_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    near_q |=> !near_q);
  p_near_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    near_q |-> busy_o);
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(cur_flat) && $stable(min_idx_q)));
endmodule

// File: tb/vit_acs_update_tb.sv
module vit_acs_update_tb;
  localparam int C = 6, N = 32, T = 64, BW = 16, DEPTH = 8, WORDS = 2;
  localparam int PMAX = (1 << 24) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [T*BW-1:0] bm_i = '0;
  logic busy_o, dec_we_o, near_ovf_o;
  logic [2:0] dec_addr_o;
  logic [15:0] dec_data_o;
  logic [4:0] min_idx_o;

  vit_acs_update #(.C(C), .BANK_DEPTH(DEPTH)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int pm [N];
  int bm [T];
  int exp_addr = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_stage(input bit stray);
    int nxt [N];
    int dec [N];
    int mi, near;
    for (int k = 0; k < T; k++) bm_i[k*BW +: BW] = 16'(bm[k]);
    near = 0;
    for (int s = 0; s < N; s++) begin
      int p0, c0, c1;
      p0 = (2*s) % N;
      c0 = pm[p0] + bm[2*s];       if (c0 > PMAX) c0 = PMAX;   // R4
      c1 = pm[p0+1] + bm[2*s+1];   if (c1 > PMAX) c1 = PMAX;
      dec[s] = (c1 < c0) ? 1 : 0;                               // R3
      nxt[s] = (c1 < c0) ? c1 : c0;                             // R2
      if (nxt[s] >= 'hC00000) near = 1;
    end
    mi = 0;
    for (int s = 1; s < N; s++) if (nxt[s] < nxt[mi]) mi = s;
    for (int s = 0; s < N; s++) pm[s] = nxt[s];
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      int ew;
      ew = 0;
      for (int b = 0; b < 16; b++) ew |= dec[16*w+b] << b;
      check("R7 we", int'(dec_we_o), 1);
      check("R7 data", int'(dec_data_o), ew);
      check("R8 addr", int'(dec_addr_o), exp_addr);
      exp_addr = (exp_addr + 1) % DEPTH;
      check("R5 near", int'(near_ovf_o), (w == 0) ? near : 0);
      check("R6 min_idx", int'(min_idx_o), mi);
      if (stray && w == 0) begin
        // R9: a stray start with different metrics must be ignored
        for (int k = 0; k < T; k++) bm_i[k*BW +: BW] = 16'(k * 7);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    check("R7 busy end", int'(busy_o), 0);
    check("R9 min_idx hold", int'(min_idx_o), mi);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int s = 0; s < N; s++) pm[s] = 0;
    repeat (3) @(negedge clk_i);
    check("R1 busy", int'(busy_o), 0);
    check("R1 we", int'(dec_we_o), 0);
    check("R1 near", int'(near_ovf_o), 0);
    check("R1 min_idx", int'(min_idx_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // equal metrics: all ties
    for (int k = 0; k < T; k++) bm[k] = 5;
    run_stage(1'b0);
    // second predecessor favoured
    for (int k = 0; k < T; k++) bm[k] = (k % 2 == 0) ? 100 : 0;
    run_stage(1'b0);
    // random metrics, with stray starts
    for (int i = 0; i < 24; i++) begin
      for (int k = 0; k < T; k++) bm[k] = int'($urandom_range(0, 65535));
      run_stage(i % 5 == 2);
    end
    // single cheap path
    for (int k = 0; k < T; k++) bm[k] = (k == 37) ? 0 : 900;
    run_stage(1'b0);
    // drive toward the ceiling: near-overflow then saturation (R4, R5)
    for (int i = 0; i < 290; i++) begin
      for (int k = 0; k < T; k++) bm[k] = (i % 3 == 0) ? int'($urandom_range(60000, 65535)) : 65535;
      run_stage(1'b0);
    end
    // saturated ties
    for (int k = 0; k < T; k++) bm[k] = 65535;
    run_stage(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule